// File: doc/BRIEF.md
# Burst CRC-8 Checksum Generator

This block watches the beats of one 16-beat burst on a 16-bit memory channel and builds an 8-bit error-detection checksum over them. Each beat contributes 18 bits: the 16 data bits and the two per-byte inversion flags. The memory side always produces the checksum, for reads and for writes alike. The result is shifted out serially on a single error-detection line and is also presented in parallel with a one-cycle strobe.

Two reporting rates are supported. At full rate the block reports one checksum per half burst: one covers beats 0 to 7 and the other covers beats 8 to 15. At half rate it forms the same two intermediate checksums and then folds them into one 8-bit value per burst. The fold runs the second intermediate through the same CRC, using the first intermediate as the seed. The rate is chosen by an input that is sampled with the first beat of each burst. The source may stall between beats.

Top module: `edc_burst_crc`

## Requirements
- R1: After reset, crc_valid_o, done_o, edc_o, edc_busy_o and crc_o are all zero, and the next accepted beat is beat 0 of a burst.
- R2: The CRC uses the polynomial x^8+x^2+x+1 (0x07) with an all-zero seed, shifted MSB first. Beats are taken in order, and within a beat the bits are taken as data bit 15 down to bit 0, then flag bit 1, then flag bit 0.
- R3: In full-rate mode (half_rate_i = 0 at beat 0), crc_valid_o pulses for one cycle after beat 7 is accepted, with the CRC of beats 0 to 7. It pulses again one cycle after beat 15, with the CRC of beats 8 to 15 restarted from a zero seed.
- R4: In half-rate mode (half_rate_i = 1 at beat 0), crc_valid_o stays low after beat 7. It pulses once, one cycle after beat 15, with the CRC of the 8 bits of the second intermediate (MSB first) seeded with the first intermediate.
- R5: done_o pulses for exactly one cycle, one cycle after beat 15 is accepted, in both modes, and at no other time.
- R6: The rate is sampled only with beat 0. Changes on half_rate_i during beats 1 to 15 have no effect on that burst.
- R7: A cycle with beat_valid_i low neither advances the beat count nor changes any checksum, whatever is on the data and flag inputs.
- R8: In the 8 cycles after each crc_valid_o pulse, edc_busy_o is high and edc_o carries the checksum MSB first. At all other times both are low.
- R9: In half-rate mode, changing any single data or flag bit of a burst changes the reported checksum.
- R10: Asserting rst_ni low during a burst discards the partial burst. The next accepted beat is treated as beat 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| half_rate_i | input | 1 | Rate select, 1 = half rate, sampled with beat 0 |
| beat_valid_i | input | 1 | A beat is presented this cycle |
| beat_data_i | input | 16 | Beat data |
| beat_inv_i | input | 2 | Per-byte inversion flags of the beat |
| crc_o | output | 8 | Last checksum produced |
| crc_valid_o | output | 1 | One-cycle strobe, crc_o is new |
| done_o | output | 1 | One-cycle strobe after the last beat of a burst |
| edc_o | output | 1 | Serial checksum, MSB first |
| edc_busy_o | output | 1 | edc_o carries a checksum bit |

## Verification
The bench targets a design that fails to restart the second half from a zero seed, which would report a chained value at full rate. It also targets a design that reads the rate on every beat, which would change reporting when the mode toggles mid-burst. Beats are interleaved with idle cycles that carry random data, so a design that absorbs stalled beats corrupts every following checksum. Back-to-back full-rate bursts place each serializer load on the last bit of the previous one, so an overrun drops or truncates bits. Single-bit flips in either half, including the inversion flags, show up a fold that ignores one intermediate or the flag bits.

// File: rtl/edc_crc_pkg.sv
package edc_crc_pkg;
  localparam int CRC_W = 8;
  localparam logic [CRC_W-1:0] CRC_POLY = 8'h07;

  typedef enum logic {
    MODE_FULL = 1'b0,
    MODE_HALF = 1'b1
  } rate_mode_e;
endpackage

// File: rtl/edc_crc_step.sv
// Combinational CRC advance over IN_W bits, MSB first.
module edc_crc_step
  import edc_crc_pkg::*;
#(
  parameter int IN_W = 18
) (
  input  logic [CRC_W-1:0] seed_i,
  input  logic [IN_W-1:0]  bits_i,
  output logic [CRC_W-1:0] crc_o
);
  always_comb begin
    logic [CRC_W-1:0] c;
    logic fb;
    c = seed_i;
    for (int i = IN_W - 1; i >= 0; i--) begin
      fb = c[CRC_W-1] ^ bits_i[i];
      c  = {c[CRC_W-2:0], 1'b0} ^ ({CRC_W{fb}} & CRC_POLY);
    end
    crc_o = c;
  end
endmodule

// File: rtl/edc_beat_ctrl.sv
module edc_beat_ctrl
  import edc_crc_pkg::*;
#(
  parameter int BEATS = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       beat_valid_i,
  input  logic       half_rate_i,
  output logic       restart_o,
  output logic       half_end_o,
  output logic       burst_end_o,
  output rate_mode_e mode_o
);
  localparam int HALF_BEATS = BEATS / 2;
  localparam int CNT_W      = $clog2(BEATS);

  logic [CNT_W-1:0] cnt_q;
  rate_mode_e       mode_q;
  logic             first_beat;

  assign first_beat  = (cnt_q == '0);
  assign restart_o   = first_beat || (cnt_q == CNT_W'(HALF_BEATS));
  assign half_end_o  = beat_valid_i && (cnt_q == CNT_W'(HALF_BEATS - 1));
  assign burst_end_o = beat_valid_i && (cnt_q == CNT_W'(BEATS - 1));
  assign mode_o      = first_beat ? rate_mode_e'(half_rate_i) : mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      mode_q <= MODE_FULL;
    end else if (beat_valid_i) begin
      cnt_q <= burst_end_o ? '0 : cnt_q + 1'b1;
      if (first_beat) mode_q <= rate_mode_e'(half_rate_i);
    end
  end

  a_r7_stall_holds_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !beat_valid_i |=> $stable(cnt_q));

  a_r6_mode_held_in_burst: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (beat_valid_i && !first_beat) |=> $stable(mode_q));
endmodule

// File: rtl/edc_serializer.sv
module edc_serializer #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] din_i,
  output logic         edc_o,
  output logic         busy_o
);
  localparam int CNT_W = $clog2(W + 1);

  logic [W-1:0]     shift_q;
  logic [CNT_W-1:0] cnt_q;

  assign busy_o = (cnt_q != '0);
  assign edc_o  = busy_o & shift_q[W-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shift_q <= '0;
      cnt_q   <= '0;
    end else if (load_i) begin
      shift_q <= din_i;
      cnt_q   <= CNT_W'(W);
    end else if (busy_o) begin
      shift_q <= {shift_q[W-2:0], 1'b0};
      cnt_q   <= cnt_q - 1'b1;
    end
  end

  // A new word may only land on the last bit of the previous one.
  a_r8_no_overrun: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> (cnt_q <= CNT_W'(1)));

  a_r8_msb_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (busy_o && edc_o == $past(din_i[W-1])));
endmodule

// File: rtl/edc_burst_crc.sv
module edc_burst_crc
  import edc_crc_pkg::*;
#(
  parameter int BEATS  = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              half_rate_i,
  input  logic              beat_valid_i,
  input  logic [DATA_W-1:0] beat_data_i,
  input  logic [DATA_W/8-1:0] beat_inv_i,
  output logic [CRC_W-1:0]  crc_o,
  output logic              crc_valid_o,
  output logic              done_o,
  output logic              edc_o,
  output logic              edc_busy_o
);
  localparam int INV_W  = DATA_W / 8;
  localparam int WORD_W = DATA_W + INV_W;

  logic             restart, half_end, burst_end;
  rate_mode_e       mode;
  logic [WORD_W-1:0] word;
  logic [CRC_W-1:0] seed, acc_next, fold;
  logic [CRC_W-1:0] acc_q, mid_q, crc_q;
  logic             valid_q, done_q;

  edc_beat_ctrl #(.BEATS(BEATS)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .beat_valid_i(beat_valid_i),
    .half_rate_i (half_rate_i),
    .restart_o   (restart),
    .half_end_o  (half_end),
    .burst_end_o (burst_end),
    .mode_o      (mode)
  );

  // Data bits first (MSB down), then the inversion flags.
  assign word = {beat_data_i, beat_inv_i};
  assign seed = restart ? '0 : acc_q;

  edc_crc_step #(.IN_W(WORD_W)) u_beat (
    .seed_i(seed),
    .bits_i(word),
    .crc_o (acc_next)
  );

  edc_crc_step #(.IN_W(CRC_W)) u_fold (
    .seed_i(mid_q),
    .bits_i(acc_next),
    .crc_o (fold)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q   <= '0;
      mid_q   <= '0;
      crc_q   <= '0;
      valid_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      valid_q <= (half_end && mode == MODE_FULL) || burst_end;
      done_q  <= burst_end;
      if (beat_valid_i) acc_q <= acc_next;
      if (half_end) mid_q <= acc_next;
      if (half_end && mode == MODE_FULL) crc_q <= acc_next;
      else if (burst_end) crc_q <= (mode == MODE_HALF) ? fold : acc_next;
    end
  end

  assign crc_o       = crc_q;
  assign crc_valid_o = valid_q;
  assign done_o      = done_q;

  edc_serializer #(.W(CRC_W)) u_ser (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(valid_q),
    .din_i (crc_q),
    .edc_o (edc_o),
    .busy_o(edc_busy_o)
  );

  a_r5_done_after_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    burst_end |=> done_o);

  a_r5_done_with_crc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> crc_valid_o);

  a_r3_full_mid_report: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (half_end && mode == MODE_FULL) |=> (crc_valid_o && !done_o));

  a_r4_half_no_mid_report: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (half_end && mode == MODE_HALF) |=> !crc_valid_o);
endmodule

// File: tb/tb_edc_burst_crc.sv
module tb_edc_burst_crc;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        half_rate_i = 1'b0;
  logic        beat_valid_i = 1'b0;
  logic [15:0] beat_data_i = '0;
  logic [1:0]  beat_inv_i = '0;
  logic [7:0]  crc_o;
  logic        crc_valid_o, done_o, edc_o, edc_busy_o;

  edc_burst_crc dut (
    .clk_i(clk), .rst_ni(rst_ni), .half_rate_i(half_rate_i),
    .beat_valid_i(beat_valid_i), .beat_data_i(beat_data_i),
    .beat_inv_i(beat_inv_i), .crc_o(crc_o), .crc_valid_o(crc_valid_o),
    .done_o(done_o), .edc_o(edc_o), .edc_busy_o(edc_busy_o)
  );

  always #5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int    n_chk = 0, n_fail = 0;
  string cur_req = "R1";
  bit    chk_en = 0;
  logic [7:0] last_crc = '0;

  logic [7:0] ev_crc[int];
  bit         ev_done[int];
  bit         ev_edc[int];

  logic [15:0] bd[16];
  logic [1:0]  bi[16];

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  // Per-cycle comparison against the scheduled expectations.
  always @(negedge clk) begin
    if (chk_en) begin
      check(cur_req, "crc_valid", 32'(crc_valid_o), 32'(ev_crc.exists(cyc)));
      if (ev_crc.exists(cyc)) check(cur_req, "crc", 32'(crc_o), 32'(ev_crc[cyc]));
      if (crc_valid_o) last_crc = crc_o;
      check("R5", "done", 32'(done_o), 32'(ev_done.exists(cyc)));
      check("R8", "edc_busy", 32'(edc_busy_o), 32'(ev_edc.exists(cyc)));
      check("R8", "edc", 32'(edc_o), ev_edc.exists(cyc) ? 32'(ev_edc[cyc]) : 32'd0);
    end
  end

  function automatic logic [7:0] crc_push(logic [7:0] c, logic b);
    logic fb;
    fb = c[7] ^ b;
    c = {c[6:0], 1'b0};
    if (fb) c = c ^ 8'h07;
    return c;
  endfunction

  function automatic logic [7:0] crc_beats(int first, int last);
    logic [7:0] c;
    c = 8'h00;
    for (int b = first; b <= last; b++) begin
      for (int k = 15; k >= 0; k--) c = crc_push(c, bd[b][k]);
      for (int k = 1; k >= 0; k--) c = crc_push(c, bi[b][k]);
    end
    return c;
  endfunction

  function automatic logic [7:0] crc_fold(logic [7:0] c1, logic [7:0] c2);
    logic [7:0] c;
    c = c1;
    for (int k = 7; k >= 0; k--) c = crc_push(c, c2[k]);
    return c;
  endfunction

  task automatic sched(int c, logic [7:0] v, bit last);
    ev_crc[c+1] = v;
    if (last) ev_done[c+1] = 1'b1;
    for (int i = 0; i < 8; i++) ev_edc[c+2+i] = v[7-i];
  endtask

  task automatic fill_random();
    for (int j = 0; j < 16; j++) begin
      bd[j] = 16'($urandom);
      bi[j] = 2'($urandom);
    end
  endtask

  task automatic idle(int n);
    repeat (n) begin
      @(negedge clk);
      beat_valid_i = 1'b0;
      beat_data_i  = 16'($urandom);
      beat_inv_i   = 2'($urandom);
    end
  endtask

  task automatic run_burst(bit half, bit gaps, bit flip_mode);
    logic [7:0] c1, c2;
    int c;
    c1 = crc_beats(0, 7);
    c2 = crc_beats(8, 15);
    for (int j = 0; j < 16; j++) begin
      if (gaps) idle(int'($urandom % 3));
      @(negedge clk);
      beat_valid_i = 1'b1;
      beat_data_i  = bd[j];
      beat_inv_i   = bi[j];
      half_rate_i  = (j != 0 && flip_mode) ? ~half : half;
      c = cyc;
      if (j == 7 && !half) sched(c, c1, 1'b0);
      if (j == 15) sched(c, half ? crc_fold(c1, c2) : c2, 1'b1);
    end
  endtask

  initial begin
    #(200000 * 10);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [7:0] base;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", "crc_valid", 32'(crc_valid_o), 0);
    check("R1", "done", 32'(done_o), 0);
    check("R1", "edc", 32'(edc_o), 0);
    check("R1", "edc_busy", 32'(edc_busy_o), 0);
    check("R1", "crc", 32'(crc_o), 0);
    rst_ni = 1'b1;
    chk_en = 1;
    idle(2);

    // R2 known vector: only flag bit 0 of beats 7 and 15 set
    cur_req = "R2";
    for (int j = 0; j < 16; j++) begin bd[j] = '0; bi[j] = '0; end
    bi[7] = 2'b01; bi[15] = 2'b01;
    run_burst(1'b0, 1'b0, 1'b0);
    idle(12);
    check("R2", "known_vector", 32'(last_crc), 32'h07);

    // R3 full rate, random, contiguous
    cur_req = "R3";
    for (int n = 0; n < 4; n++) begin
      fill_random();
      run_burst(1'b0, 1'b0, 1'b0);
      idle(12);
    end

    // R4 half rate
    cur_req = "R4";
    for (int n = 0; n < 4; n++) begin
      fill_random();
      run_burst(1'b1, 1'b0, 1'b0);
      idle(12);
    end

    // R7 stalls with garbage on the inputs
    cur_req = "R7";
    for (int n = 0; n < 4; n++) begin
      fill_random();
      run_burst(1'(n & 1), 1'b1, 1'b0);
      idle(12);
    end

    // R6 mode toggled after beat 0
    cur_req = "R6";
    for (int n = 0; n < 4; n++) begin
      fill_random();
      run_burst(1'(n & 1), 1'(n >> 1), 1'b1);
      idle(12);
    end

    // R3 back-to-back bursts, mixed modes, serializer fully loaded
    cur_req = "R3";
    fill_random(); run_burst(1'b0, 1'b0, 1'b0);
    fill_random(); run_burst(1'b0, 1'b0, 1'b0);
    fill_random(); run_burst(1'b1, 1'b0, 1'b0);
    fill_random(); run_burst(1'b0, 1'b0, 1'b0);
    idle(12);

    // R9 single-bit flips change the half-rate result
    cur_req = "R9";
    fill_random();
    run_burst(1'b1, 1'b0, 1'b0);
    idle(12);
    base = last_crc;
    bd[3][0] = ~bd[3][0];
    run_burst(1'b1, 1'b0, 1'b0); idle(12);
    check("R9", "flip_data_first_half", 32'(last_crc != base), 1);
    bd[3][0] = ~bd[3][0];
    bd[12][15] = ~bd[12][15];
    run_burst(1'b1, 1'b0, 1'b0); idle(12);
    check("R9", "flip_data_second_half", 32'(last_crc != base), 1);
    bd[12][15] = ~bd[12][15];
    bi[9][1] = ~bi[9][1];
    run_burst(1'b1, 1'b0, 1'b0); idle(12);
    check("R9", "flip_flag", 32'(last_crc != base), 1);
    bi[9][1] = ~bi[9][1];
    bi[0][0] = ~bi[0][0];
    run_burst(1'b1, 1'b0, 1'b0); idle(12);
    check("R9", "flip_flag_beat0", 32'(last_crc != base), 1);

    // R10 reset in the middle of a burst
    cur_req = "R10";
    fill_random();
    for (int j = 0; j < 5; j++) begin
      @(negedge clk);
      beat_valid_i = 1'b1;
      beat_data_i  = 16'($urandom);
      beat_inv_i   = 2'($urandom);
    end
    @(negedge clk);
    beat_valid_i = 1'b0;
    rst_ni = 1'b0;
    @(negedge clk);
    check("R10", "crc_after_reset", 32'(crc_o), 0);
    check("R10", "busy_after_reset", 32'(edc_busy_o), 0);
    rst_ni = 1'b1;
    idle(1);
    run_burst(1'b0, 1'b0, 1'b0);
    idle(12);
    run_burst(1'b1, 1'b1, 1'b0);
    idle(12);

    chk_en = 0;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule